// File: doc/BRIEF.md
# Threshold Offset Loader for a Dual FIFO

This block holds the four threshold offsets used by a pair of FIFOs: for each FIFO, an almost-empty offset and an almost-full offset. The surrounding FIFO logic compares its fill levels against these values. Storage and the comparison itself are outside this block. Until all four offsets hold valid values, the block keeps its `ready` output low. The FIFO logic uses this output to hold off normal operation.

A three-bit mode select is captured on every clock edge while the synchronous master reset `rst` is high. The value seen on the last reset edge picks one of three ways to obtain the offsets. The first is a preset value copied into all four offsets. The second is a serial stream of bits, each qualified by an enable. The third is four word writes from a parallel bus. All loaded values are saturated into the legal range of 1 to DEPTH-4. A partial reset `prst` drops `ready` for as long as it is held. It keeps the offsets and any loading progress, so normal operation resumes without reloading.

Top module: `offs_loader`

## Requirements
- R1: On every clock edge where `rst` is high, `ready` goes low and `mode_sel` is captured; in serial and parallel modes the four offsets read 0 after reset until they are loaded. The offset registers are ordered as ae1, af1, ae2, af2.
- R2: `mode_sel` values 0, 1, 2, 3 and 4 select the preset offsets 8, 16, 64, 256 and 1024 respectively. The preset is placed in all four offsets during reset. `ready` is high after the first clock edge with `rst` low.
- R3: `mode_sel` = 5 selects serial loading. A bit on `ser_bit` is taken only on edges where `ser_en` is high. The 4·W bits (W = log2 DEPTH) fill ae1, af1, ae2, af2 in that order, with the first bit the MSB of ae1 and the last bit the LSB of af2.
- R4: In serial mode the offsets keep their reset value of 0 and `ready` stays low until the last bit is taken. On the edge that takes the last bit, all four offsets update together and `ready` goes high.
- R5: `mode_sel` = 6 or 7 selects parallel loading. Each edge with `par_wr` high loads the next offset in the order ae1, af1, ae2, af2, using the value of `par_bus` read as an unsigned number. `ready` goes high on the edge of the fourth write.
- R6: Any loaded value of 0 is stored as 1, and any value above DEPTH-4 is stored as DEPTH-4. This applies to serial, parallel and preset values alike.
- R7: Once loading is complete, `ser_en`, `ser_bit`, `par_wr` and `par_bus` have no effect on the offsets until the next master reset.
- R8: On an edge with `prst` high, `ready` goes low. On the first edge with `prst` low after that, `ready` returns to its loaded state. `prst` never changes the offsets or the loading progress.
- R9: While `ready` is high, the offsets do not change on the next edge unless a master reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| prst | input | 1 | Synchronous active-high partial reset |
| mode_sel | input | 3 | Load mode / preset select, captured during reset |
| ser_en | input | 1 | Serial bit qualifier |
| ser_bit | input | 1 | Serial data bit |
| par_wr | input | 1 | Parallel write strobe |
| par_bus | input | BUS_W | Parallel offset value |
| ofs_ae1 | output | W | Almost-empty offset, FIFO 1 |
| ofs_af1 | output | W | Almost-full offset, FIFO 1 |
| ofs_ae2 | output | W | Almost-empty offset, FIFO 2 |
| ofs_af2 | output | W | Almost-full offset, FIFO 2 |
| ready | output | 1 | All offsets loaded; normal operation allowed |

## Verification
The assertions check four things on every cycle. `ready` drops after a master or partial reset. The offsets stay inside 1 to DEPTH-4 whenever `ready` is high. The offsets hold still while `ready` stays high. `ready` never rises directly out of a partial reset. The bench scenarios cover what a single-cycle property cannot see. These are the MSB-first bit ordering across the four registers, the skipping of non-enabled serial cycles, the parallel write order and the preset table. They also include saturation of out-of-range values, retention of progress across a partial reset, and the inertness of stimulus after loading completes.

// File: rtl/offs_pkg.sv
package offs_pkg;

  typedef enum logic [1:0] {
    MODE_PRESET   = 2'd0,
    MODE_SERIAL   = 2'd1,
    MODE_PARALLEL = 2'd2
  } load_mode_e;

  function automatic load_mode_e decode_mode(input logic [2:0] s);
    if (s == 3'd5)      return MODE_SERIAL;
    else if (s >= 3'd6) return MODE_PARALLEL;
    else                return MODE_PRESET;
  endfunction

  function automatic logic [31:0] preset_value(input logic [2:0] s);
    case (s)
      3'd0:    return 32'd8;
      3'd1:    return 32'd16;
      3'd2:    return 32'd64;
      3'd3:    return 32'd256;
      default: return 32'd1024;
    endcase
  endfunction

endpackage

// File: rtl/offs_mode_latch.sv
module offs_mode_latch
  import offs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel_i,
  output load_mode_e mode_o
);
  load_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= decode_mode(sel_i);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/offs_clamp.sv
module offs_clamp #(
  parameter int IW   = 11,
  parameter int W    = 11,
  parameter int MAXO = 2044
) (
  input  logic [IW-1:0] in_i,
  output logic [W-1:0]  out_o
);
  localparam logic [IW+W-1:0] MAX_WIDE = (IW+W)'(MAXO);
  logic [IW+W-1:0] wide;

  assign wide = {{W{1'b0}}, in_i};

  always_comb begin
    if (wide == '0)            out_o = W'(1);
    else if (wide > MAX_WIDE)  out_o = W'(MAXO);
    else                       out_o = wide[W-1:0];
  end
endmodule

// File: rtl/offs_serial_shift.sv
module offs_serial_shift #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         bit_en_i,
  input  logic         bit_i,
  output logic [4*W-1:0] word_o,
  output logic         fire_o
);
  localparam int TOT = 4 * W;
  localparam int CW  = $clog2(TOT);
  localparam logic [CW-1:0] LAST = CW'(TOT - 1);

  logic [TOT-2:0] shift_q;
  logic [CW-1:0]  cnt_q;
  logic           take;

  assign take   = en_i && bit_en_i;
  assign fire_o = take && (cnt_q == LAST);
  assign word_o = {shift_q, bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (take) begin
      shift_q <= {shift_q[TOT-3:0], bit_i};
      cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/offs_par_seq.sv
module offs_par_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       wr_i,
  output logic [3:0] we_o,
  output logic       last_o
);
  logic [1:0] idx_q;
  logic       take;

  assign take   = en_i && wr_i;
  assign last_o = take && (idx_q == 2'd3);

  for (genvar i = 0; i < 4; i++) begin : g_we
    assign we_o[i] = take && (idx_q == 2'(i));
  end

  always_ff @(posedge clk) begin
    if (rst)       idx_q <= '0;
    else if (take) idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/offs_loader.sv
module offs_loader
  import offs_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int BUS_W = 36,
  localparam int W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prst,
  input  logic [2:0]       mode_sel,
  input  logic             ser_en,
  input  logic             ser_bit,
  input  logic             par_wr,
  input  logic [BUS_W-1:0] par_bus,
  output logic [W-1:0]     ofs_ae1,
  output logic [W-1:0]     ofs_af1,
  output logic [W-1:0]     ofs_ae2,
  output logic [W-1:0]     ofs_af2,
  output logic             ready
);
  localparam int MAXO = DEPTH - 4;
  localparam int TOT  = 4 * W;

  load_mode_e     mode_q;
  logic           loaded_q, loaded_d, ready_q;
  logic           ser_active, par_active, ser_fire, par_last;
  logic [TOT-1:0] ser_word;
  logic [3:0]     par_we;
  logic [W-1:0]   par_val, preset_val;
  logic [W-1:0]   ser_val [4];
  logic [W-1:0]   ofs_q   [4];
  logic           is_preset_sel;

  offs_mode_latch u_mode (
    .clk(clk), .rst(rst), .sel_i(mode_sel), .mode_o(mode_q)
  );

  assign ser_active = !rst && !loaded_q && (mode_q == MODE_SERIAL);
  assign par_active = !rst && !loaded_q && (mode_q == MODE_PARALLEL);

  offs_serial_shift #(.W(W)) u_ser (
    .clk(clk), .rst(rst), .en_i(ser_active), .bit_en_i(ser_en),
    .bit_i(ser_bit), .word_o(ser_word), .fire_o(ser_fire)
  );

  offs_par_seq u_par (
    .clk(clk), .rst(rst), .en_i(par_active), .wr_i(par_wr),
    .we_o(par_we), .last_o(par_last)
  );

  offs_clamp #(.IW(BUS_W), .W(W), .MAXO(MAXO)) u_clamp_par (
    .in_i(par_bus), .out_o(par_val)
  );

  offs_clamp #(.IW(32), .W(W), .MAXO(MAXO)) u_clamp_pre (
    .in_i(preset_value(mode_sel)), .out_o(preset_val)
  );

  assign is_preset_sel = (decode_mode(mode_sel) == MODE_PRESET);

  for (genvar i = 0; i < 4; i++) begin : g_ofs
    offs_clamp #(.IW(W), .W(W), .MAXO(MAXO)) u_clamp_ser (
      .in_i(ser_word[TOT-1-i*W -: W]), .out_o(ser_val[i])
    );

    always_ff @(posedge clk) begin
      if (rst)            ofs_q[i] <= is_preset_sel ? preset_val : '0;
      else if (ser_fire)  ofs_q[i] <= ser_val[i];
      else if (par_we[i]) ofs_q[i] <= par_val;
    end
  end

  assign loaded_d = loaded_q || (mode_q == MODE_PRESET) || ser_fire || par_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded_q <= 1'b0;
      ready_q  <= 1'b0;
    end else begin
      loaded_q <= loaded_d;
      ready_q  <= loaded_d && !prst;
    end
  end

  assign ofs_ae1 = ofs_q[0];
  assign ofs_af1 = ofs_q[1];
  assign ofs_ae2 = ofs_q[2];
  assign ofs_af2 = ofs_q[3];
  assign ready   = ready_q;
endmodule

// File: rtl/offs_loader_chk.sv
module offs_loader_chk #(
  parameter int W    = 11,
  parameter int MAXO = 2044
) (
  input logic         clk,
  input logic         rst,
  input logic         prst,
  input logic         ready,
  input logic [W-1:0] ofs_ae1,
  input logic [W-1:0] ofs_af1,
  input logic [W-1:0] ofs_ae2,
  input logic [W-1:0] ofs_af2
);
  localparam logic [W-1:0] HI = W'(MAXO);

  // R1
  rst_drops_ready_chk: assert property (@(posedge clk) rst |=> !ready);

  // R8
  prst_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    prst |=> !ready);

  // R8
  ready_rise_after_prst_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> !$past(prst));

  // R6
  offs_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (ofs_ae1 >= 1 && ofs_ae1 <= HI && ofs_af1 >= 1 && ofs_af1 <= HI &&
               ofs_ae2 >= 1 && ofs_ae2 <= HI && ofs_af2 >= 1 && ofs_af2 <= HI));

  // R9
  offs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ($stable(ofs_ae1) && $stable(ofs_af1) &&
               $stable(ofs_ae2) && $stable(ofs_af2)));
endmodule

bind offs_loader offs_loader_chk #(.W(W), .MAXO(MAXO)) u_chk (
  .clk(clk), .rst(rst), .prst(prst), .ready(ready),
  .ofs_ae1(ofs_ae1), .ofs_af1(ofs_af1), .ofs_ae2(ofs_ae2), .ofs_af2(ofs_af2)
);

// File: tb/sim_offs_loader.sv
module sim_offs_loader;
  localparam int DEPTH = 2048;
  localparam int BUS_W = 36;
  localparam int W     = $clog2(DEPTH);
  localparam int MAXO  = DEPTH - 4;

  logic clk = 0, rst = 1, prst = 0, ser_en = 0, ser_bit = 0, par_wr = 0;
  logic [2:0] mode_sel = 0;
  logic [BUS_W-1:0] par_bus = '0;
  logic [W-1:0] ofs_ae1, ofs_af1, ofs_ae2, ofs_af2;
  logic ready;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  offs_loader #(.DEPTH(DEPTH), .BUS_W(BUS_W)) u0 (
    .clk(clk), .rst(rst), .prst(prst), .mode_sel(mode_sel), .ser_en(ser_en),
    .ser_bit(ser_bit), .par_wr(par_wr), .par_bus(par_bus),
    .ofs_ae1(ofs_ae1), .ofs_af1(ofs_af1), .ofs_ae2(ofs_ae2), .ofs_af2(ofs_af2),
    .ready(ready)
  );

  function automatic logic [W-1:0] sat(input logic [63:0] v);
    if (v == 0) return W'(1);
    if (v > MAXO) return W'(MAXO);
    return v[W-1:0];
  endfunction

  function automatic logic [W-1:0] preset_of(input int s);
    case (s)
      0: return sat(8);
      1: return sat(16);
      2: return sat(64);
      3: return sat(256);
      default: return sat(1024);
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ofs(input string req, input logic [W-1:0] e0, input logic [W-1:0] e1,
                         input logic [W-1:0] e2, input logic [W-1:0] e3);
    chk({req, " ae1"}, ofs_ae1, e0);
    chk({req, " af1"}, ofs_af1, e1);
    chk({req, " ae2"}, ofs_ae2, e2);
    chk({req, " af2"}, ofs_af2, e3);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int s);
    rst = 1; mode_sel = 3'(s);
    repeat (4) tick();
    chk("R1 ready in reset", ready, 0);
    rst = 0;
  endtask

  task automatic ser_load(input logic [W-1:0] v [4], input int gap);
    logic [4*W-1:0] stream;
    stream = {v[0], v[1], v[2], v[3]};
    for (int k = 4*W-1; k >= 0; k--) begin
      int idle = (gap > 0) ? int'($urandom_range(gap, 0)) : 0;
      for (int g = 0; g < idle; g++) begin
        ser_en = 0; ser_bit = 1'($urandom);
        tick();
      end
      if (k == 0) begin
        chk("R4 ready before last bit", ready, 0);
        chk_ofs("R4 offsets before last bit", 0, 0, 0, 0);
      end
      ser_en = 1; ser_bit = stream[k];
      tick();
    end
    ser_en = 0;
  endtask

  initial begin
    logic [W-1:0] v [4];
    logic [BUS_W-1:0] pv [4];
    logic [W-1:0] held [4];
    void'($urandom(32'd20240611));

    // R2 presets
    for (int s = 0; s < 5; s++) begin
      do_reset(s);
      chk_ofs("R2 preset", preset_of(s), preset_of(s), preset_of(s), preset_of(s));
      tick();
      chk("R2 ready after preset", ready, 1);
    end

    // R3 R4 R6 serial, directed clamp corners then random
    for (int t = 0; t < 6; t++) begin
      do_reset(5);
      chk_ofs("R1 serial cleared", 0, 0, 0, 0);
      if (t == 0) begin
        v[0] = 0; v[1] = 2047; v[2] = 1; v[3] = W'(MAXO);
      end else if (t == 1) begin
        v[0] = 11'h400; v[1] = 11'h001; v[2] = 11'h2AA; v[3] = 11'h555;
      end else begin
        for (int i = 0; i < 4; i++) v[i] = W'($urandom);
      end
      ser_load(v, (t < 2) ? 0 : 3);
      chk("R4 ready after last bit", ready, 1);
      chk_ofs("R3 R6 serial values", sat(v[0]), sat(v[1]), sat(v[2]), sat(v[3]));
    end

    // R7 serial stimulus after completion
    ser_en = 1;
    for (int k = 0; k < 10; k++) begin
      ser_bit = 1'($urandom); tick();
    end
    ser_en = 0;
    chk_ofs("R7 serial ignored", sat(v[0]), sat(v[1]), sat(v[2]), sat(v[3]));

    // R8 partial reset after load
    prst = 1; tick();
    chk("R8 ready low in prst", ready, 0);
    chk_ofs("R8 offsets kept", sat(v[0]), sat(v[1]), sat(v[2]), sat(v[3]));
    prst = 0; tick();
    chk("R8 ready back", ready, 1);

    // R5 R6 R8 parallel with a partial reset in the middle
    for (int t = 0; t < 4; t++) begin
      do_reset((t % 2 == 0) ? 6 : 7);
      chk_ofs("R1 parallel cleared", 0, 0, 0, 0);
      for (int i = 0; i < 4; i++) begin
        pv[i] = (t == 0) ? ((i == 0) ? '0 : (i == 1) ? BUS_W'(64'h8_0000_0001) :
                            (i == 2) ? BUS_W'(MAXO) : BUS_W'(MAXO + 1))
                         : BUS_W'($urandom_range(2100, 0));
        held[i] = 0;
      end
      for (int i = 0; i < 4; i++) begin
        if (t == 1 && i == 2) begin
          prst = 1; par_wr = 0; tick(); prst = 0;
          chk_ofs("R8 progress kept", held[0], held[1], 0, 0);
        end
        par_wr = 1; par_bus = pv[i];
        tick();
        par_wr = 0;
        held[i] = sat(64'(pv[i]));
        chk("R5 ready vs write count", ready, (i == 3) ? 1 : 0);
        chk_ofs("R5 R6 parallel", held[0], held[1], held[2], held[3]);
      end
    end

    // R7 parallel writes after completion
    par_wr = 1;
    for (int k = 0; k < 4; k++) begin
      par_bus = BUS_W'($urandom); tick();
    end
    par_wr = 0;
    chk_ofs("R7 parallel ignored", held[0], held[1], held[2], held[3]);

    // R1 new master reset overrides loaded state
    do_reset(3);
    chk_ofs("R1 reload preset", preset_of(3), preset_of(3), preset_of(3), preset_of(3));
    tick();
    chk("R2 ready after reload", ready, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule